// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two identical 8+8-bit timer/counters behind a byte-wide register port. A mode register picks, for each timer, whether it is gated by an external pin, whether it counts a periodic tick or falling edges on an external count pin, and which of four arrangements its low byte (TL) and high byte (TH) take. These are a 13-bit counter with a prescaler, a 16-bit cascade, an 8-bit counter that reloads itself, and a split arrangement. In the split arrangement timer 0 becomes two independent 8-bit counters and timer 1 is frozen. A control register holds the run bits, the overflow flags and two external-interrupt flags that watch the gate pins.

Software writes the mode, loads TL/TH and sets the run bits. The overflow flags leave the block as interrupt requests. They are cleared by an acknowledge strobe from the interrupt controller or by a software write. All four external pins pass through a synchronizer before they are used.

Top module: `dual_tmr_unit`

## Requirements
- R1: After reset every register (control, mode, TL0, TH0, TL1, TH1) reads 0x00 and both interrupt outputs are low.
- R2: Register addresses are 0 control, 1 mode, 2 TL0, 3 TH0, 4 TL1, 5 TH1. Addresses 6 and 7 read 0x00 and ignore writes. Control bits 7..0 are: flag1, run1, flag0, run0, extflag1, extmode1, extflag0, extmode0. Mode bits 7..4 configure timer 1 and bits 3..0 configure timer 0, each nibble ordered gate, source, mode-high, mode-low.
- R3: A timer advances only while its run bit is 1 and either its gate bit is 0 or its synchronized gate pin is high.
- R4: With source 0 a timer advances once per cycle in which `tick` is high. With source 1 it advances once per falling edge on its count pin, three clock edges after the pin falls, and ignores `tick`.
- R5: Mode 0 (mode bits 00): TL[4:0] is a 5-bit prescaler. When it wraps from 31, TH increments. When TH is also 0xFF the flag is set. TL[7:5] keep their value.
- R6: Mode 1 (01): {TH,TL} is a 16-bit counter. Stepping from 0xFFFF to 0x0000 sets the flag.
- R7: Mode 2 (10): TL counts. When it steps past 0xFF it is loaded from TH, TH is unchanged, and the flag is set.
- R8: Mode 3 (11) on timer 0 splits it. TL0 counts under timer 0's run, gate and source bits and sets flag0. TH0 counts ticks while run1 is set and sets flag1. Timer 1 overflows then no longer set flag1. Timer 1 in mode 3 holds TL1 and TH1.
- R9: An acknowledge strobe clears the matching flag, and a software write may also change it. A hardware set in the same cycle as a write or an acknowledge leaves the flag at 1.
- R10: A software write to TL or TH in the same cycle as an increment stores the written value.
- R11: With extmode 1 a falling edge on the gate pin sets extflag, which stays set until software writes 0. With extmode 0 extflag follows the inverted synchronized gate pin.
- R12: `ovf_irq[1]` and `ovf_irq[0]` equal flag1 and flag0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Periodic enable for internal timing |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cnt_pin | input | 2 | External count pins, bit i for timer i |
| gate_pin | input | 2 | External gate / interrupt pins, bit i for timer i |
| irq_ack | input | 2 | Interrupt acknowledge strobes, bit i clears flag i |
| ovf_irq | output | 2 | Overflow flags as interrupt requests |

## Verification
Two pairs of functions can land in the same cycle. A hardware overflow can coincide with a software write of the control register or with an acknowledge strobe. A counter increment can coincide with a software write of the byte it is stepping. The bench provokes each collision by raising `tick` on a counter at its terminal value in the same cycle as the write or acknowledge, or on an ordinary value in the same cycle as a TL write. It then reads the control register or TL back through the port and expects the set flag (R9) or the written byte (R10) to have won.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      MD_13BIT  = 2'b00,
      MD_16BIT  = 2'b01,
      MD_RELOAD = 2'b10,
      MD_SPLIT  = 2'b11
   } tmr_mode_e;

   localparam logic [2:0] RA_CTL  = 3'd0;
   localparam logic [2:0] RA_MODE = 3'd1;
   localparam logic [2:0] RA_TL0  = 3'd2;
   localparam logic [2:0] RA_TH0  = 3'd3;
   localparam logic [2:0] RA_TL1  = 3'd4;
   localparam logic [2:0] RA_TH1  = 3'd5;

endpackage

// File: rtl/tmr_pinsync.sv
module tmr_pinsync #(
   parameter int   WIDTH   = 4,
   parameter int   STAGES  = 2,
   parameter logic IDLE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_pinsync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
      logic [STAGES:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {(STAGES+1){IDLE}};
         else        chain <= {chain[STAGES-1:0], pin[b]};
      end
      assign lvl[b]  = chain[STAGES-1];
      assign fall[b] = chain[STAGES] & ~chain[STAGES-1];
   end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
   import tmr_pkg::*;
#(
   parameter int PS_BITS = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  tmr_mode_e  mode,
   input  logic       adv_lo,
   input  logic       adv_hi,
   input  logic       wr_lo,
   input  logic       wr_hi,
   input  logic [7:0] wdata,
   output logic [7:0] tl_q,
   output logic [7:0] th_q,
   output logic       ovf_main,
   output logic       ovf_split
);

   if (PS_BITS < 1 || PS_BITS > 7) begin : g_bad_ps
      $error("tmr_counter: PS_BITS must lie in 1..7");
   end

   localparam logic [PS_BITS-1:0] PS_MAX = {PS_BITS{1'b1}};

   logic [7:0] tl_d, th_d;

   always_comb begin
      tl_d      = tl_q;
      th_d      = th_q;
      ovf_main  = 1'b0;
      ovf_split = 1'b0;
      unique case (mode)
         MD_13BIT: if (adv_lo) begin
            if (tl_q[PS_BITS-1:0] == PS_MAX) begin
               tl_d[PS_BITS-1:0] = '0;
               th_d              = th_q + 8'd1;
               ovf_main          = (th_q == 8'hFF);
            end else begin
               tl_d[PS_BITS-1:0] = tl_q[PS_BITS-1:0] + 1'b1;
            end
         end
         MD_16BIT: if (adv_lo) begin
            {th_d, tl_d} = {th_q, tl_q} + 16'd1;
            ovf_main     = &{th_q, tl_q};
         end
         MD_RELOAD: if (adv_lo) begin
            if (&tl_q) begin
               tl_d     = th_q;
               ovf_main = 1'b1;
            end else begin
               tl_d = tl_q + 8'd1;
            end
         end
         MD_SPLIT: begin
            if (adv_lo) begin
               tl_d     = tl_q + 8'd1;
               ovf_main = &tl_q;
            end
            if (adv_hi) begin
               th_d      = th_q + 8'd1;
               ovf_split = &th_q;
            end
         end
         default: ;
      endcase
      // software store beats the increment
      if (wr_lo) tl_d = wdata;
      if (wr_hi) th_d = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tl_q <= '0;
         th_q <= '0;
      end else begin
         tl_q <= tl_d;
         th_q <= th_d;
      end
   end

endmodule

// File: rtl/dual_tmr_unit.sv
module dual_tmr_unit
   import tmr_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter int   PS_BITS     = 5,
   parameter logic PIN_IDLE    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [2:0] reg_addr,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic [1:0] cnt_pin,
   input  logic [1:0] gate_pin,
   input  logic [1:0] irq_ack,
   output logic [1:0] ovf_irq
);

   localparam int NT = 2;

   logic [7:0]         ctl_q, ctl_d, mode_q;
   logic [NT-1:0][7:0] tl_v, th_v;
   logic [NT-1:0]      ovf_main, ovf_split, set_flag;
   logic [NT-1:0]      gate_lvl, gate_fall, cnt_fall;
   logic [NT-1:0]      cnt_lvl_unused;
   logic               t0_split;

   tmr_pinsync #(.WIDTH(2*NT), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  ({gate_pin, cnt_pin}),
      .lvl  ({gate_lvl, cnt_lvl_unused}),
      .fall ({gate_fall, cnt_fall})
   );

   assign t0_split = (mode_q[1:0] == MD_SPLIT);

   for (genvar i = 0; i < NT; i++) begin : g_tmr
      logic       cfg_gate, cfg_src, run, evt, adv_lo, adv_hi;
      tmr_mode_e  md;

      assign cfg_gate = mode_q[4*i+3];
      assign cfg_src  = mode_q[4*i+2];
      assign md       = tmr_mode_e'(mode_q[4*i +: 2]);
      assign run      = ctl_q[4+2*i] & (~cfg_gate | gate_lvl[i]);
      assign evt      = cfg_src ? cnt_fall[i] : tick;

      if (i == 0) begin : g_t0
         assign adv_lo = run & evt;
         assign adv_hi = ctl_q[6] & tick;
      end else begin : g_tn
         assign adv_lo = run & evt & (md != MD_SPLIT);
         assign adv_hi = 1'b0;
      end

      tmr_counter #(.PS_BITS(PS_BITS)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .mode     (md),
         .adv_lo   (adv_lo),
         .adv_hi   (adv_hi),
         .wr_lo    (reg_wr && reg_addr == 3'(2 + 2*i)),
         .wr_hi    (reg_wr && reg_addr == 3'(3 + 2*i)),
         .wdata    (reg_wdata),
         .tl_q     (tl_v[i]),
         .th_q     (th_v[i]),
         .ovf_main (ovf_main[i]),
         .ovf_split(ovf_split[i])
      );
   end

   assign set_flag[0] = ovf_main[0];
   assign set_flag[1] = t0_split ? ovf_split[0] : (ovf_main[1] | ovf_split[1]);

   always_comb begin
      ctl_d = ctl_q;
      if (reg_wr && reg_addr == RA_CTL) ctl_d = reg_wdata;
      for (int k = 0; k < NT; k++) begin
         if (irq_ack[k])  ctl_d[5+2*k] = 1'b0;
         if (set_flag[k]) ctl_d[5+2*k] = 1'b1;
         if (ctl_d[2*k]) begin
            if (gate_fall[k]) ctl_d[1+2*k] = 1'b1;
         end else begin
            ctl_d[1+2*k] = ~gate_lvl[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         mode_q <= '0;
      end else begin
         ctl_q <= ctl_d;
         if (reg_wr && reg_addr == RA_MODE) mode_q <= reg_wdata;
      end
   end

   always_comb begin
      unique case (reg_addr)
         RA_CTL:  reg_rdata = ctl_q;
         RA_MODE: reg_rdata = mode_q;
         RA_TL0:  reg_rdata = tl_v[0];
         RA_TH0:  reg_rdata = th_v[0];
         RA_TL1:  reg_rdata = tl_v[1];
         RA_TH1:  reg_rdata = th_v[1];
         default: reg_rdata = 8'h00;
      endcase
   end

   assign ovf_irq = {ctl_q[7], ctl_q[5]};

endmodule

// File: rtl/dual_tmr_unit_chk.sv
module dual_tmr_unit_chk (
   input logic            clk,
   input logic            rst_n,
   input logic [2:0]      reg_addr,
   input logic            reg_wr,
   input logic [7:0]      reg_wdata,
   input logic [1:0]      irq_ack,
   input logic [1:0]      ovf_irq,
   input logic [7:0]      ctl_q,
   input logic [7:0]      mode_q,
   input logic [1:0]      set_flag,
   input logic [1:0][7:0] tl_v,
   input logic [1:0][7:0] th_v
);

   a_r3_stopped_tl0_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[4] && !(reg_wr && reg_addr == 3'd2)) |=> $stable(tl_v[0]));

   a_r8_t1_frozen_in_split: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[5:4] == 2'b11 && !(reg_wr && (reg_addr == 3'd4 || reg_addr == 3'd5)))
      |=> ($stable(tl_v[1]) && $stable(th_v[1])));

   a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      set_flag[0] |=> ovf_irq[0]);

   a_r9_ack_clears_flag1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[1] && !set_flag[1] && !(reg_wr && reg_addr == 3'd0)) |=> !ovf_irq[1]);

   a_r7_reload_from_th0: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1:0] == 2'b10 && set_flag[0] && !(reg_wr && reg_addr == 3'd2))
      |=> (tl_v[0] == $past(th_v[0])));

   a_r10_store_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd2) |=> (tl_v[0] == $past(reg_wdata)));

endmodule

bind dual_tmr_unit dual_tmr_unit_chk u_chk (.*);

// File: tb/dual_tmr_unit_test.sv
`timescale 1ns/1ps
module dual_tmr_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [1:0] cnt_pin = 2'b11;
   logic [1:0] gate_pin = 2'b11;
   logic [1:0] irq_ack = 2'b00;
   logic [1:0] ovf_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_tmr_unit uut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cnt_pin(cnt_pin), .gate_pin(gate_pin), .irq_ack(irq_ack), .ovf_irq(ovf_irq)
   );

   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
   localparam int NV = 62;
   // {op, addr, data or tick count, expected read}
   localparam logic [20:0] VEC [NV] = '{
      // R6: 16-bit cascade carry from TL0 into TH0
      {OP_WR,3'd1,8'h01,8'h00}, {OP_WR,3'd2,8'hFE,8'h00}, {OP_WR,3'd3,8'h12,8'h00},
      {OP_WR,3'd0,8'h10,8'h00}, {OP_TK,3'd0,8'd3,8'h00},  {OP_WR,3'd0,8'h00,8'h00},
      {OP_RD,3'd2,8'h00,8'h01}, {OP_RD,3'd3,8'h00,8'h13}, {OP_RD,3'd0,8'h00,8'h00},
      // R6: 0xFFFF wraps and sets flag0
      {OP_WR,3'd2,8'hFF,8'h00}, {OP_WR,3'd3,8'hFF,8'h00}, {OP_WR,3'd0,8'h10,8'h00},
      {OP_TK,3'd0,8'd1,8'h00},  {OP_RD,3'd0,8'h00,8'h30}, {OP_RD,3'd2,8'h00,8'h00},
      {OP_RD,3'd3,8'h00,8'h00}, {OP_WR,3'd0,8'h00,8'h00},
      // R5: 13-bit mode on timer 1, TL1[7:5] kept
      {OP_WR,3'd4,8'hFE,8'h00}, {OP_WR,3'd5,8'hFF,8'h00}, {OP_WR,3'd0,8'h40,8'h00},
      {OP_TK,3'd0,8'd1,8'h00},  {OP_RD,3'd4,8'h00,8'hFF}, {OP_TK,3'd0,8'd1,8'h00},
      {OP_RD,3'd4,8'h00,8'hE0}, {OP_RD,3'd5,8'h00,8'h00}, {OP_RD,3'd0,8'h00,8'hC0},
      {OP_WR,3'd0,8'h00,8'h00},
      // R7: auto-reload from TH0
      {OP_WR,3'd1,8'h02,8'h00}, {OP_WR,3'd2,8'hFE,8'h00}, {OP_WR,3'd3,8'h80,8'h00},
      {OP_WR,3'd0,8'h10,8'h00}, {OP_TK,3'd0,8'd2,8'h00},  {OP_RD,3'd2,8'h00,8'h80},
      {OP_RD,3'd0,8'h00,8'h30}, {OP_TK,3'd0,8'd1,8'h00},  {OP_RD,3'd2,8'h00,8'h81},
      {OP_RD,3'd3,8'h00,8'h80}, {OP_WR,3'd0,8'h00,8'h00},
      // R8: timer 0 split, TH0 driven by run1 and setting flag1
      {OP_WR,3'd1,8'h13,8'h00}, {OP_WR,3'd2,8'hFF,8'h00}, {OP_WR,3'd3,8'hFE,8'h00},
      {OP_WR,3'd4,8'h55,8'h00}, {OP_WR,3'd5,8'h00,8'h00}, {OP_WR,3'd0,8'h50,8'h00},
      {OP_TK,3'd0,8'd2,8'h00},  {OP_RD,3'd2,8'h00,8'h01}, {OP_RD,3'd3,8'h00,8'h00},
      {OP_RD,3'd0,8'h00,8'hF0}, {OP_RD,3'd4,8'h00,8'h57}, {OP_RD,3'd5,8'h00,8'h00},
      {OP_WR,3'd0,8'h00,8'h00},
      // R8: timer 1 in mode 3 holds
      {OP_WR,3'd1,8'h31,8'h00}, {OP_WR,3'd0,8'h40,8'h00}, {OP_TK,3'd0,8'd3,8'h00},
      {OP_RD,3'd4,8'h00,8'h57}, {OP_RD,3'd0,8'h00,8'h40}, {OP_WR,3'd0,8'h00,8'h00},
      // R2: unmapped addresses, mode readback
      {OP_WR,3'd6,8'hAA,8'h00}, {OP_RD,3'd6,8'h00,8'h00}, {OP_RD,3'd7,8'h00,8'h00},
      {OP_RD,3'd1,8'h00,8'h31}, {OP_RD,3'd0,8'h00,8'h00}
   };

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1 chk(reg_rdata, exp, req);
   endtask

   task automatic tk(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 reset register");
      #1 chk({6'd0, ovf_irq}, 8'h00, "R1 reset irq");

      for (int v = 0; v < NV; v++) begin
         logic [1:0] op;
         logic [2:0] a;
         logic [7:0] d, e;
         {op, a, d, e} = VEC[v];
         case (op)
            OP_WR: wr(a, d);
            OP_TK: tk(int'(d));
            default: rd(a, e, $sformatf("table vector %0d", v));
         endcase
      end

      // R8: timer 1 overflow does not set flag1 while timer 0 is split
      wr(3'd1, 8'h13); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd3, 8'h00);
      wr(3'd0, 8'h40); tk(1);
      rd(3'd0, 8'h40, "R8 no flag1 from timer1");
      rd(3'd4, 8'h00, "R8 timer1 still counts");
      rd(3'd3, 8'h01, "R8 TH0 counts under run1");
      wr(3'd0, 8'h00);

      // R3: gate pin holds the timer
      wr(3'd1, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
      gate_pin[0] = 1'b0; idle(3);
      wr(3'd0, 8'h10); tk(4);
      rd(3'd2, 8'h00, "R3 gated low");
      gate_pin[0] = 1'b1; idle(3);
      tk(4);
      rd(3'd2, 8'h04, "R3 gate high");
      wr(3'd0, 8'h00);

      // R4: counting falling edges on the count pin
      wr(3'd1, 8'h05); wr(3'd2, 8'h00); wr(3'd0, 8'h10);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk) cnt_pin[0] = 1'b0;
         idle(3);
         cnt_pin[0] = 1'b1;
         idle(3);
      end
      idle(3);
      rd(3'd2, 8'h03, "R4 pin edges");
      tk(5);
      rd(3'd2, 8'h03, "R4 tick ignored in pin mode");
      wr(3'd0, 8'h00);

      // R12 and R9: flag to output, acknowledge clears
      wr(3'd0, 8'h20);
      @(negedge clk); #1 chk({6'd0, ovf_irq}, 8'h01, "R12 irq mirrors flag0");
      @(negedge clk) irq_ack = 2'b01;
      @(negedge clk) irq_ack = 2'b00;
      rd(3'd0, 8'h00, "R9 ack clears flag0");
      #1 chk({6'd0, ovf_irq}, 8'h00, "R12 irq low after ack");

      // R9: overflow in the same cycle as a control write
      wr(3'd1, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd0, 8'h10);
      @(negedge clk);
      tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h10;
      @(negedge clk);
      tick = 1'b0; reg_wr = 1'b0;
      rd(3'd0, 8'h30, "R9 set beats write");
      // R9: overflow in the same cycle as an acknowledge
      wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
      @(negedge clk);
      tick = 1'b1; irq_ack = 2'b01;
      @(negedge clk);
      tick = 1'b0; irq_ack = 2'b00;
      rd(3'd0, 8'h30, "R9 set beats ack");

      // R10: store in the same cycle as an increment
      wr(3'd2, 8'h10); wr(3'd3, 8'h00);
      @(negedge clk);
      tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h40;
      @(negedge clk);
      tick = 1'b0; reg_wr = 1'b0;
      rd(3'd2, 8'h40, "R10 store beats step");
      rd(3'd3, 8'h00, "R10 TH0 untouched");
      wr(3'd0, 8'h00);

      // R11: edge mode on gate pin 1
      wr(3'd0, 8'h04);
      @(negedge clk) gate_pin[1] = 1'b0;
      idle(4);
      rd(3'd0, 8'h0C, "R11 edge sets extflag1");
      gate_pin[1] = 1'b1; idle(4);
      rd(3'd0, 8'h0C, "R11 extflag1 sticky");
      wr(3'd0, 8'h04);
      rd(3'd0, 8'h04, "R11 software clears extflag1");
      // R11: level mode on gate pin 0
      wr(3'd0, 8'h00);
      @(negedge clk) gate_pin[0] = 1'b0;
      idle(4);
      rd(3'd0, 8'h02, "R11 level low sets extflag0");
      gate_pin[0] = 1'b1; idle(4);
      rd(3'd0, 8'h00, "R11 level high clears extflag0");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule